// File: doc/BRIEF.md
# DMA Channel Address Sequencer

This block walks the source and destination byte addresses of one DMA channel while a block of data moves. A one-cycle `start` pulse captures the channel settings: both start addresses, the block length in bytes, and for each side the transaction width, the burst length, the address update mode, and a group size and skip distance. The group size and skip distance let the source read in gathered runs and the destination write in scattered runs. The sequencer then offers one address per side on a valid/ready pair. It advances that side each time the bus engine accepts a transaction.

Each side has its own remaining-byte counter, so the two sides may use different widths and move at different rates. A `last` flag marks the final transaction of every burst. When both counters are empty the block is done. The sequencer then sets sticky interrupt status bits, each gated by its own enable. Start addresses and skip distances that are not aligned to their side's width put the channel into a fault state, and in that state it offers no transaction.

Back-pressure rules: a side's valid stays high, with a stable address and `last`, until its ready is seen high at a rising edge. Ready may toggle freely and has no effect while valid is low. Valid never waits for ready.

Top module: `dma_addr_seq`

## Requirements
- R1: On a `start` pulse with aligned settings, all settings are captured. From the next cycle each side asserts valid with its address equal to its start address. A new `start` restarts the block at any time.
- R2: Update mode per side: 0 adds the transaction width after each accepted transaction, 1 subtracts it, and 2 or 3 keeps the address unchanged.
- R3: Width select per side: 0, 1, 2 and 3 mean 1, 2, 4 and 8 bytes. This is both the address step and the amount taken from that side's byte counter.
- R4: Burst select per side: 0, 1, 2 and 3 mean 1, 4, 8 and 16 transactions per burst. The `last` output is high on the final transaction of each burst, and also on the final transaction of the block.
- R5: Source grouping: in increment or decrement mode with a non-zero group size, the address moves a further skip distance in the same direction once a contiguous run reaches the group size. After that the run restarts. A group size of 0, or fixed mode, disables the skip.
- R6: Destination grouping follows the same rule as R5, using the destination group size and skip distance.
- R7: Each side's counter loads the block length, with a length of 0 meaning 2^LEN_W bytes. A side is valid until its counter reaches zero.
- R8: `blk_done` is high in every cycle that both counters are zero after an error-free start. While it is high neither side is valid, and it stays high until the next `start`.
- R9: While valid is high and ready is low, the side's valid, address and `last` hold.
- R10: A start address or skip distance on either side that is not a multiple of that side's width raises `chan_err` from the next cycle, and no valid asserts until a good `start`.
- R11: Status bit 0 marks end of transfer: the block ended and `xfer_last` was high at `start`. Bit 1 marks end of block, and bit 2 marks an error. Each bit is set only if its enable is high; the bit 0 and bit 1 enables are captured at `start`. The bit for a block end is set one cycle after `blk_done` rises. The error bit is set at the `start` edge.
- R12: Status bits stay set until a 1 is written to the same position of `irq_clr`. If a set and a clear arrive in the same cycle, the bit stays set. `irq` is high whenever any status bit is set.
- R13: Under reset both valids, `blk_done`, `chan_err`, all status bits and `irq` are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| start | input | 1 | One-cycle pulse: capture settings and begin a block |
| xfer_last | input | 1 | Block is the final one of the transfer |
| src_base | input | ADDR_W | Source start address |
| dst_base | input | ADDR_W | Destination start address |
| blk_len | input | LEN_W | Block length in bytes, 0 = 2^LEN_W |
| src_wsel | input | 2 | Source transaction width select |
| dst_wsel | input | 2 | Destination transaction width select |
| src_bsel | input | 2 | Source burst length select |
| dst_bsel | input | 2 | Destination burst length select |
| src_mode | input | 2 | Source address update mode |
| dst_mode | input | 2 | Destination address update mode |
| src_grp | input | GS_W | Source contiguous group size in bytes, 0 = off |
| src_skip | input | GS_W | Source skip distance in bytes |
| dst_grp | input | GS_W | Destination contiguous group size in bytes, 0 = off |
| dst_skip | input | GS_W | Destination skip distance in bytes |
| ie_xfer | input | 1 | Enable for the end-of-transfer status bit |
| ie_blk | input | 1 | Enable for the end-of-block status bit |
| ie_err | input | 1 | Enable for the error status bit |
| src_valid | output | 1 | Source transaction offered |
| src_ready | input | 1 | Source transaction accepted |
| src_addr | output | ADDR_W | Current source address |
| src_last | output | 1 | Final source transaction of a burst or block |
| dst_valid | output | 1 | Destination transaction offered |
| dst_ready | input | 1 | Destination transaction accepted |
| dst_addr | output | ADDR_W | Current destination address |
| dst_last | output | 1 | Final destination transaction of a burst or block |
| blk_done | output | 1 | Both byte counters are exhausted |
| chan_err | output | 1 | Channel is held in the alignment fault state |
| irq_clr | input | 3 | Write-one-to-clear pulses for the status bits |
| irq_status | output | 3 | Sticky status: bit 0 transfer end, bit 1 block end, bit 2 error |
| irq | output | 1 | Any status bit set |

## Verification
The hold and status properties assume that `start` is a single-cycle pulse. They also assume that the settings are steady in the cycle it is sampled. The block length is taken to be a multiple of both widths, and each group size a multiple of its side's width, so that no side ends on a partial transaction. The stimulus draws every length and group size as such a multiple, including the maximum block length. It toggles ready in different patterns on the two sides, so that valid is held against back-pressure on both. The alignment faults are reached only through deliberately misaligned start addresses or skip distances.

// File: rtl/dma_seq_pkg.sv
package dma_seq_pkg;

  typedef enum logic [1:0] {
    UPD_INC  = 2'd0,
    UPD_DEC  = 2'd1,
    UPD_FIX  = 2'd2,
    UPD_HOLD = 2'd3
  } upd_mode_e;

  typedef enum logic [1:0] {
    CH_IDLE  = 2'd0,
    CH_RUN   = 2'd1,
    CH_FAULT = 2'd2
  } ch_state_e;

  localparam int ST_XFER = 0;
  localparam int ST_BLK  = 1;
  localparam int ST_ERR  = 2;
  localparam int ST_BITS = 3;

  // bytes moved by one transaction
  function automatic logic [3:0] step_bytes(input logic [1:0] wsel);
    return 4'd1 << wsel;
  endfunction

  // transactions per burst
  function automatic logic [4:0] burst_beats(input logic [1:0] bsel);
    return (bsel == 2'd0) ? 5'd1 : (5'd2 << bsel);
  endfunction

  function automatic logic misaligned(input logic [2:0] lo, input logic [1:0] wsel);
    logic [3:0] mask;
    mask = step_bytes(wsel) - 4'd1;
    return |(lo & mask[2:0]);
  endfunction

endpackage

// File: rtl/dma_addr_side.sv
module dma_addr_side
  import dma_seq_pkg::*;
#(
  parameter int ADDR_W = 32,
  parameter int LEN_W  = 16,
  parameter int GS_W   = 12
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              load,
  input  logic [ADDR_W-1:0] base,
  input  logic [LEN_W-1:0]  len,
  input  logic [1:0]        wsel,
  input  logic [1:0]        bsel,
  input  logic [1:0]        mode,
  input  logic [GS_W-1:0]   grp,
  input  logic [GS_W-1:0]   skip,
  input  logic              enable,
  input  logic              ready,
  output logic              valid,
  output logic [ADDR_W-1:0] addr,
  output logic              last,
  output logic              empty
);

  localparam int RW = LEN_W + 1;

  upd_mode_e         mode_q;
  logic [1:0]        wsel_q, bsel_q;
  logic [GS_W-1:0]   grp_q, skip_q;
  logic [ADDR_W-1:0] addr_q, addr_nxt;
  logic [RW-1:0]     rem_q, len_full;
  logic [GS_W-1:0]   run_q;
  logic [4:0]        beat_q, beats;
  logic [3:0]        step;
  logic [RW-1:0]     step_r;
  logic [ADDR_W-1:0] step_a, jump_a;
  logic [GS_W:0]     run_sum;
  logic              moving, wrap, fire;

  assign step     = step_bytes(wsel_q);
  assign step_r   = {{(RW-4){1'b0}}, step};
  assign step_a   = {{(ADDR_W-4){1'b0}}, step};
  assign beats    = burst_beats(bsel_q);
  assign len_full = (len == '0) ? {1'b1, {LEN_W{1'b0}}} : {1'b0, len};

  assign moving  = (mode_q == UPD_INC) || (mode_q == UPD_DEC);
  assign run_sum = {1'b0, run_q} + {{(GS_W-3){1'b0}}, step};
  assign wrap    = moving && (grp_q != '0) && (run_sum >= {1'b0, grp_q});
  assign jump_a  = wrap ? {{(ADDR_W-GS_W){1'b0}}, skip_q} : '0;

  always_comb begin
    case (mode_q)
      UPD_INC: addr_nxt = addr_q + step_a + jump_a;
      UPD_DEC: addr_nxt = addr_q - step_a - jump_a;
      default: addr_nxt = addr_q;
    endcase
  end

  assign empty = (rem_q == '0);
  assign valid = enable && !empty;
  assign fire  = valid && ready;
  assign addr  = addr_q;
  assign last  = (beat_q == beats - 5'd1) || (rem_q <= step_r);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      mode_q <= UPD_INC;
      wsel_q <= '0;
      bsel_q <= '0;
      grp_q  <= '0;
      skip_q <= '0;
      addr_q <= '0;
      rem_q  <= '0;
      run_q  <= '0;
      beat_q <= '0;
    end else if (load) begin
      mode_q <= upd_mode_e'(mode);
      wsel_q <= wsel;
      bsel_q <= bsel;
      grp_q  <= grp;
      skip_q <= skip;
      addr_q <= base;
      rem_q  <= len_full;
      run_q  <= '0;
      beat_q <= '0;
    end else if (fire) begin
      addr_q <= addr_nxt;
      rem_q  <= (rem_q > step_r) ? (rem_q - step_r) : '0;
      run_q  <= wrap ? '0 : run_sum[GS_W-1:0];
      beat_q <= last ? 5'd0 : (beat_q + 5'd1);
    end
  end

endmodule

// File: rtl/dma_chan_ctrl.sv
module dma_chan_ctrl
  import dma_seq_pkg::*;
(
  input  logic               clk,
  input  logic               rst_n,
  input  logic               start,
  input  logic               xfer_last,
  input  logic [2:0]         src_lo,
  input  logic [2:0]         dst_lo,
  input  logic [2:0]         src_skip_lo,
  input  logic [2:0]         dst_skip_lo,
  input  logic [1:0]         src_wsel,
  input  logic [1:0]         dst_wsel,
  input  logic               ie_xfer,
  input  logic               ie_blk,
  input  logic               ie_err,
  input  logic               src_empty,
  input  logic               dst_empty,
  output logic               run_en,
  output logic               blk_done,
  output logic               chan_err,
  output logic [ST_BITS-1:0] st_set
);

  ch_state_e state_q;
  logic      last_q, iex_q, ieb_q, done_q, bad, done_edge;

  assign bad = misaligned(src_lo, src_wsel) || misaligned(src_skip_lo, src_wsel) ||
               misaligned(dst_lo, dst_wsel) || misaligned(dst_skip_lo, dst_wsel);

  assign run_en    = (state_q == CH_RUN);
  assign chan_err  = (state_q == CH_FAULT);
  assign blk_done  = run_en && src_empty && dst_empty;
  assign done_edge = blk_done && !done_q;

  assign st_set[ST_XFER] = done_edge && last_q && iex_q;
  assign st_set[ST_BLK]  = done_edge && ieb_q;
  assign st_set[ST_ERR]  = start && bad && ie_err;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= CH_IDLE;
      last_q  <= 1'b0;
      iex_q   <= 1'b0;
      ieb_q   <= 1'b0;
      done_q  <= 1'b0;
    end else begin
      done_q <= blk_done;
      if (start) begin
        state_q <= bad ? CH_FAULT : CH_RUN;
        last_q  <= xfer_last;
        iex_q   <= ie_xfer;
        ieb_q   <= ie_blk;
      end
    end
  end

endmodule

// File: rtl/dma_irq_stat.sv
module dma_irq_stat #(
  parameter int NB = 3
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic [NB-1:0] set,
  input  logic [NB-1:0] clr,
  output logic [NB-1:0] status,
  output logic          any
);

  for (genvar i = 0; i < NB; i++) begin : g_bit
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)      status[i] <= 1'b0;
      else if (set[i]) status[i] <= 1'b1;
      else if (clr[i]) status[i] <= 1'b0;
    end
  end

  assign any = |status;

endmodule

// File: rtl/dma_addr_seq.sv
module dma_addr_seq
  import dma_seq_pkg::*;
#(
  parameter int ADDR_W = 32,
  parameter int LEN_W  = 16,
  parameter int GS_W   = 12
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              start,
  input  logic              xfer_last,
  input  logic [ADDR_W-1:0] src_base,
  input  logic [ADDR_W-1:0] dst_base,
  input  logic [LEN_W-1:0]  blk_len,
  input  logic [1:0]        src_wsel,
  input  logic [1:0]        dst_wsel,
  input  logic [1:0]        src_bsel,
  input  logic [1:0]        dst_bsel,
  input  logic [1:0]        src_mode,
  input  logic [1:0]        dst_mode,
  input  logic [GS_W-1:0]   src_grp,
  input  logic [GS_W-1:0]   src_skip,
  input  logic [GS_W-1:0]   dst_grp,
  input  logic [GS_W-1:0]   dst_skip,
  input  logic              ie_xfer,
  input  logic              ie_blk,
  input  logic              ie_err,
  output logic              src_valid,
  input  logic              src_ready,
  output logic [ADDR_W-1:0] src_addr,
  output logic              src_last,
  output logic              dst_valid,
  input  logic              dst_ready,
  output logic [ADDR_W-1:0] dst_addr,
  output logic              dst_last,
  output logic              blk_done,
  output logic              chan_err,
  input  logic [2:0]        irq_clr,
  output logic [2:0]        irq_status,
  output logic              irq
);

  logic               run_en, src_empty, dst_empty;
  logic [ST_BITS-1:0] st_set;

  dma_chan_ctrl u_ctrl (
    .clk        (clk),
    .rst_n      (rst_n),
    .start      (start),
    .xfer_last  (xfer_last),
    .src_lo     (src_base[2:0]),
    .dst_lo     (dst_base[2:0]),
    .src_skip_lo(src_skip[2:0]),
    .dst_skip_lo(dst_skip[2:0]),
    .src_wsel   (src_wsel),
    .dst_wsel   (dst_wsel),
    .ie_xfer    (ie_xfer),
    .ie_blk     (ie_blk),
    .ie_err     (ie_err),
    .src_empty  (src_empty),
    .dst_empty  (dst_empty),
    .run_en     (run_en),
    .blk_done   (blk_done),
    .chan_err   (chan_err),
    .st_set     (st_set)
  );

  dma_addr_side #(.ADDR_W(ADDR_W), .LEN_W(LEN_W), .GS_W(GS_W)) u_src (
    .clk   (clk),
    .rst_n (rst_n),
    .load  (start),
    .base  (src_base),
    .len   (blk_len),
    .wsel  (src_wsel),
    .bsel  (src_bsel),
    .mode  (src_mode),
    .grp   (src_grp),
    .skip  (src_skip),
    .enable(run_en),
    .ready (src_ready),
    .valid (src_valid),
    .addr  (src_addr),
    .last  (src_last),
    .empty (src_empty)
  );

  dma_addr_side #(.ADDR_W(ADDR_W), .LEN_W(LEN_W), .GS_W(GS_W)) u_dst (
    .clk   (clk),
    .rst_n (rst_n),
    .load  (start),
    .base  (dst_base),
    .len   (blk_len),
    .wsel  (dst_wsel),
    .bsel  (dst_bsel),
    .mode  (dst_mode),
    .grp   (dst_grp),
    .skip  (dst_skip),
    .enable(run_en),
    .ready (dst_ready),
    .valid (dst_valid),
    .addr  (dst_addr),
    .last  (dst_last),
    .empty (dst_empty)
  );

  dma_irq_stat #(.NB(ST_BITS)) u_irq (
    .clk   (clk),
    .rst_n (rst_n),
    .set   (st_set),
    .clr   (irq_clr),
    .status(irq_status),
    .any   (irq)
  );

endmodule

// File: rtl/dma_addr_seq_chk.sv
module dma_addr_seq_chk #(
  parameter int ADDR_W = 32
) (
  input logic              clk,
  input logic              rst_n,
  input logic              start,
  input logic              src_valid,
  input logic              src_ready,
  input logic [ADDR_W-1:0] src_addr,
  input logic              src_last,
  input logic              dst_valid,
  input logic              dst_ready,
  input logic [ADDR_W-1:0] dst_addr,
  input logic              dst_last,
  input logic              blk_done,
  input logic              chan_err,
  input logic [2:0]        irq_clr,
  input logic [2:0]        irq_status
);

  assert_src_hold_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (src_valid && !src_ready && !start) |=> (src_valid && $stable(src_addr) && $stable(src_last)));

  assert_dst_hold_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (dst_valid && !dst_ready && !start) |=> (dst_valid && $stable(dst_addr) && $stable(dst_last)));

  assert_fault_quiet_R10: assert property (@(posedge clk) disable iff (!rst_n)
    chan_err |-> (!src_valid && !dst_valid && !blk_done));

  assert_done_quiet_R8: assert property (@(posedge clk) disable iff (!rst_n)
    blk_done |-> (!src_valid && !dst_valid));

  assert_done_hold_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (blk_done && !start) |=> blk_done);

  assert_sticky_R12: assert property (@(posedge clk) disable iff (!rst_n)
    ((irq_status & $past(irq_status & ~irq_clr)) == $past(irq_status & ~irq_clr)));

endmodule

bind dma_addr_seq dma_addr_seq_chk #(.ADDR_W(ADDR_W)) u_chk (
  .clk       (clk),
  .rst_n     (rst_n),
  .start     (start),
  .src_valid (src_valid),
  .src_ready (src_ready),
  .src_addr  (src_addr),
  .src_last  (src_last),
  .dst_valid (dst_valid),
  .dst_ready (dst_ready),
  .dst_addr  (dst_addr),
  .dst_last  (dst_last),
  .blk_done  (blk_done),
  .chan_err  (chan_err),
  .irq_clr   (irq_clr),
  .irq_status(irq_status)
);

// File: tb/sim_dma_addr_seq.sv
`timescale 1ns/1ps
module sim_dma_addr_seq;

  localparam int CLK_PERIOD = 10;

  typedef struct packed {
    logic [31:0] sb;
    logic [31:0] db;
    logic [15:0] len;
    logic [1:0]  sw, dw, sbs, dbs, sm, dm;
    logic [11:0] sgw, sgj, dgw, dgj;
    logic        bp;
    logic [15:0] ns, nd;
  } vec_t;

  localparam vec_t VECS [6] = '{
    '{32'h1000, 32'h2000, 16'd32, 2'd2, 2'd2, 2'd1, 2'd0, 2'd0, 2'd0, 12'd0, 12'd0,  12'd0,  12'd0, 1'b0, 16'd8,  16'd8},
    '{32'h0100, 32'h0300, 16'd16, 2'd1, 2'd3, 2'd0, 2'd2, 2'd1, 2'd2, 12'd0, 12'd0,  12'd8,  12'd8, 1'b1, 16'd8,  16'd2},
    '{32'h0000, 32'h0080, 16'd16, 2'd0, 2'd2, 2'd2, 2'd0, 2'd0, 2'd0, 12'd4, 12'd4,  12'd8,  12'd8, 1'b0, 16'd16, 16'd4},
    '{32'h0200, 32'h0400, 16'd32, 2'd2, 2'd1, 2'd0, 2'd3, 2'd1, 2'd0, 12'd8, 12'd16, 12'd0,  12'd0, 1'b1, 16'd8,  16'd16},
    '{32'h4000, 32'h8000, 16'd64, 2'd3, 2'd3, 2'd3, 2'd1, 2'd0, 2'd1, 12'd0, 12'd0,  12'd16, 12'd8, 1'b1, 16'd8,  16'd8},
    '{32'h0010, 32'h0020, 16'd8,  2'd0, 2'd0, 2'd0, 2'd0, 2'd3, 2'd0, 12'd2, 12'd2,  12'd0,  12'd0, 1'b0, 16'd8,  16'd8}
  };

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        start = 1'b0, xfer_last = 1'b0;
  logic [31:0] src_base = '0, dst_base = '0;
  logic [15:0] blk_len = '0;
  logic [1:0]  src_wsel = '0, dst_wsel = '0, src_bsel = '0, dst_bsel = '0;
  logic [1:0]  src_mode = '0, dst_mode = '0;
  logic [11:0] src_grp = '0, src_skip = '0, dst_grp = '0, dst_skip = '0;
  logic        ie_xfer = 1'b0, ie_blk = 1'b0, ie_err = 1'b0;
  logic        src_ready = 1'b0, dst_ready = 1'b0;
  logic [2:0]  irq_clr = '0;
  logic        src_valid, src_last, dst_valid, dst_last, blk_done, chan_err, irq;
  logic [31:0] src_addr, dst_addr;
  logic [2:0]  irq_status;

  int n_tests = 0;
  int n_fail  = 0;

  // reference walker state, index 0 = source, 1 = destination
  logic [31:0] m_addr [2];
  int          m_rem [2], m_run [2], m_beat [2];
  int          m_w [2], m_b [2], m_mode [2], m_gw [2], m_gj [2];

  always #(CLK_PERIOD/2) clk = ~clk;

  dma_addr_seq u0 (
    .clk(clk), .rst_n(rst_n), .start(start), .xfer_last(xfer_last),
    .src_base(src_base), .dst_base(dst_base), .blk_len(blk_len),
    .src_wsel(src_wsel), .dst_wsel(dst_wsel), .src_bsel(src_bsel), .dst_bsel(dst_bsel),
    .src_mode(src_mode), .dst_mode(dst_mode),
    .src_grp(src_grp), .src_skip(src_skip), .dst_grp(dst_grp), .dst_skip(dst_skip),
    .ie_xfer(ie_xfer), .ie_blk(ie_blk), .ie_err(ie_err),
    .src_valid(src_valid), .src_ready(src_ready), .src_addr(src_addr), .src_last(src_last),
    .dst_valid(dst_valid), .dst_ready(dst_ready), .dst_addr(dst_addr), .dst_last(dst_last),
    .blk_done(blk_done), .chan_err(chan_err),
    .irq_clr(irq_clr), .irq_status(irq_status), .irq(irq)
  );

  task automatic chk(input bit ok, input string tag, input logic [63:0] act, input logic [63:0] exp);
    n_tests++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s: actual %0h expected %0h", tag, act, exp);
    end
  endtask

  function automatic int m_step(input int s);
    return 1 << m_w[s];
  endfunction

  function automatic bit m_last(input int s);
    int beats;
    beats = (m_b[s] == 0) ? 1 : (2 << m_b[s]);
    return (m_beat[s] == beats - 1) || (m_rem[s] <= m_step(s));
  endfunction

  // R2 R3 R5 R6 reference update after one accepted transaction
  task automatic m_advance(input int s);
    int  st;
    bit  mv, wr, lst;
    st  = m_step(s);
    lst = m_last(s);
    mv  = (m_mode[s] == 0) || (m_mode[s] == 1);
    wr  = mv && (m_gw[s] != 0) && (m_run[s] + st >= m_gw[s]);
    if (m_mode[s] == 0) m_addr[s] = m_addr[s] + st + (wr ? m_gj[s] : 0);
    if (m_mode[s] == 1) m_addr[s] = m_addr[s] - st - (wr ? m_gj[s] : 0);
    m_run[s]  = wr ? 0 : m_run[s] + st;
    m_beat[s] = lst ? 0 : m_beat[s] + 1;
    m_rem[s]  = (m_rem[s] > st) ? m_rem[s] - st : 0;
  endtask

  task automatic drive_cfg(input vec_t v);
    src_base = v.sb;  dst_base = v.db;  blk_len = v.len;
    src_wsel = v.sw;  dst_wsel = v.dw;  src_bsel = v.sbs; dst_bsel = v.dbs;
    src_mode = v.sm;  dst_mode = v.dm;
    src_grp  = v.sgw; src_skip = v.sgj; dst_grp = v.dgw;  dst_skip = v.dgj;
  endtask

  task automatic run_vec(input vec_t v, input bit xl, input bit ie_on, input string name);
    int sn, dn, cyc;
    bit sr, dr;
    logic [2:0] exp_st;
    @(negedge clk);
    drive_cfg(v);
    xfer_last = xl; ie_xfer = ie_on; ie_blk = ie_on; ie_err = 1'b1;
    start = 1'b1;
    m_addr[0] = v.sb; m_addr[1] = v.db;
    m_rem[0] = (v.len == 0) ? 65536 : int'(v.len); m_rem[1] = m_rem[0];
    m_w[0] = v.sw;   m_w[1] = v.dw;   m_b[0] = v.sbs;  m_b[1] = v.dbs;
    m_mode[0] = v.sm; m_mode[1] = v.dm;
    m_gw[0] = v.sgw; m_gj[0] = v.sgj; m_gw[1] = v.dgw; m_gj[1] = v.dgj;
    for (int s = 0; s < 2; s++) begin m_run[s] = 0; m_beat[s] = 0; end
    @(negedge clk);
    start = 1'b0;
    // R1 first offer uses start addresses
    chk(src_valid && src_addr == v.sb, {name, " R1 src start"}, src_addr, v.sb);
    chk(dst_valid && dst_addr == v.db, {name, " R1 dst start"}, dst_addr, v.db);
    chk(!chan_err, {name, " R10 aligned start no fault"}, chan_err, 0);
    sn = 0; dn = 0; cyc = 0;
    while (!blk_done && cyc < 20000) begin
      chk(src_valid == (m_rem[0] != 0), {name, " R7 src valid"}, src_valid, m_rem[0] != 0);
      chk(dst_valid == (m_rem[1] != 0), {name, " R7 dst valid"}, dst_valid, m_rem[1] != 0);
      if (src_valid) begin
        chk(src_addr == m_addr[0], {name, " R2/R3/R5 src addr"}, src_addr, m_addr[0]);
        chk(src_last == m_last(0), {name, " R4 src last"}, src_last, m_last(0));
      end
      if (dst_valid) begin
        chk(dst_addr == m_addr[1], {name, " R2/R3/R6 dst addr"}, dst_addr, m_addr[1]);
        chk(dst_last == m_last(1), {name, " R4 dst last"}, dst_last, m_last(1));
      end
      // R9 back-pressure patterns differ per side
      sr = v.bp ? (cyc % 3 != 1) : 1'b1;
      dr = v.bp ? (cyc % 2 == 0) : 1'b1;
      src_ready = sr; dst_ready = dr;
      if (src_valid && sr) begin m_advance(0); sn++; end
      if (dst_valid && dr) begin m_advance(1); dn++; end
      @(negedge clk);
      cyc++;
    end
    src_ready = 1'b0; dst_ready = 1'b0;
    chk(sn == int'(v.ns), {name, " R7 src count"}, sn, v.ns);
    chk(dn == int'(v.nd), {name, " R7 dst count"}, dn, v.nd);
    chk(blk_done && !src_valid && !dst_valid, {name, " R8 done"}, {src_valid, dst_valid, blk_done}, 3'b001);
    exp_st = ie_on ? {1'b0, 1'b1, xl} : 3'b000;
    @(negedge clk);
    chk(irq_status == exp_st, {name, " R11 status"}, irq_status, exp_st);
    chk(irq == (exp_st != 0), {name, " R12 irq line"}, irq, exp_st != 0);
    chk(blk_done, {name, " R8 done holds"}, blk_done, 1);
    irq_clr = 3'b010;
    @(negedge clk);
    irq_clr = 3'b000;
    chk(irq_status == (exp_st & 3'b101), {name, " R12 partial clear"}, irq_status, exp_st & 3'b101);
    irq_clr = 3'b111;
    @(negedge clk);
    irq_clr = 3'b000;
    chk(irq_status == 3'b000 && !irq, {name, " R12 full clear"}, irq_status, 0);
  endtask

  task automatic bad_start(input logic [31:0] sb, input logic [11:0] dj, input bit ie, input logic [2:0] clr);
    vec_t v;
    v = VECS[4];
    v.sb = sb; v.dgj = dj;
    @(negedge clk);
    drive_cfg(v);
    ie_err = ie; start = 1'b1; irq_clr = clr;
    @(negedge clk);
    start = 1'b0; irq_clr = 3'b000;
  endtask

  initial begin
    repeat (190000) @(posedge clk);
    n_fail++;
    $display("FAIL watchdog: actual timeout expected finish");
    $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end

  initial begin
    vec_t mx;
    // R13 reset state
    repeat (3) @(negedge clk);
    chk({src_valid, dst_valid, blk_done, chan_err, irq_status, irq} == 8'h00,
        "R13 in reset", {src_valid, dst_valid, blk_done, chan_err, irq_status, irq}, 0);
    rst_n = 1'b1;
    @(negedge clk);
    chk({src_valid, dst_valid, blk_done, chan_err, irq} == 5'h00,
        "R13 after reset", {src_valid, dst_valid, blk_done, chan_err, irq}, 0);

    // table walk
    for (int i = 0; i < 6; i++) begin
      run_vec(VECS[i], i[0], 1'b1, $sformatf("vec%0d", i));
    end

    // R11 enables off: no status after block end
    run_vec(VECS[0], 1'b1, 1'b0, "ie_off");

    // R7 zero length means 2^16 bytes
    mx = VECS[0];
    mx.len = 16'd0; mx.sw = 2'd3; mx.dw = 2'd3; mx.ns = 16'd8192; mx.nd = 16'd8192;
    run_vec(mx, 1'b1, 1'b1, "maxlen");

    // R10 misaligned source start, error enabled
    bad_start(32'h4002, 12'd8, 1'b1, 3'b000);
    chk(chan_err && !src_valid && !dst_valid, "R10 src misaligned fault",
        {chan_err, src_valid, dst_valid}, 3'b100);
    chk(irq_status == 3'b100, "R11 error bit set", irq_status, 3'b100);
    src_ready = 1'b1; dst_ready = 1'b1;
    @(negedge clk);
    chk(!src_valid && !dst_valid && !blk_done, "R10 fault stays quiet",
        {src_valid, dst_valid, blk_done}, 0);
    src_ready = 1'b0; dst_ready = 1'b0;

    // R12 set and clear in the same cycle: bit stays set
    bad_start(32'h4004, 12'd8, 1'b1, 3'b100);
    chk(irq_status == 3'b100, "R12 set wins over clear", irq_status, 3'b100);
    irq_clr = 3'b100;
    @(negedge clk);
    irq_clr = 3'b000;
    chk(irq_status == 3'b000, "R12 clear error bit", irq_status, 0);

    // R10 misaligned destination skip with error disabled
    bad_start(32'h4000, 12'd4, 1'b0, 3'b000);
    chk(chan_err, "R10 dst skip misaligned", chan_err, 1);
    chk(irq_status == 3'b000, "R11 error enable off", irq_status, 0);

    // R1 recovery with a good start after a fault
    run_vec(VECS[2], 1'b0, 1'b1, "recover");

    $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end

endmodule